// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a bank of system control registers on a plain 32-bit register bus. The bus has a word index, a write strobe, write data, and read data that follows the index in the same cycle. The bank holds these registers:

- two constant identification and status words;
- a key register that unlocks two clock-oscillator setting registers;
- a control register that drives an LED, a boot-memory remap select and a one-cycle system reset request;
- a memory configuration register and a memory init register;
- two flag registers, each with its own write-one-to-set and write-one-to-clear addresses;
- a read-only window onto a small memory presence-detect table.

The installed memory size is a static parameter. It selects a size code that is folded into the reset value of the memory configuration register. It also selects the density byte in the presence-detect table. Reads of word indices that hold nothing return zero, and writes to them change nothing. This includes the four voltage-control words. A system integrator wires the bank to the register bus. It connects `remap_o` to the boot address decoder and `sys_reset_req_o` to the reset controller.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the registers hold these values: word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, word 5 reads 0, and both flag registers read 0. `led_o`, `remap_o` and `sys_reset_req_o` are low. Word 8 reads 0x00011122 OR a size code taken from `MEM_MB`: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise.
- R2: Word 0 always reads 0x411A3001. Word 4 always reads 0x00100000.
- R3: A write to word 5 stores the low 16 bits of the write data. A read of word 5 returns the stored value. Bit 16 of that read is set only when the stored value is 0xA05F.
- R4: A write to word 2 or word 7 takes effect only while word 5 holds 0xA05F. At any other time the write is ignored.
- R5: A write to word 3 stores only bit 0 (LED) and bit 2 (remap). Word 3 reads these two bits in place, and all other bits read zero, bit 3 included. `led_o` follows bit 0 and `remap_o` follows bit 2, from the cycle after the write. A high `remap_o` means the boot flash is hidden at address zero.
- R6: A write to word 3 with bit 3 set raises `sys_reset_req_o` for the one cycle after the write. The pulse does not depend on the other bits or on the lock state.
- R7: A write to word 12 ORs the write data into the main flags. A write to word 13 clears every flag bit that is 1 in the write data. The flags read at word 12, and word 13 reads zero.
- R8: Words 14 (set) and 15 (clear) work the same way on a second flag register, which reads at word 14. The two flag registers do not affect each other.
- R9: Word 8 (memory configuration) and word 9 (memory init) take every bit of a write and read back what was written.
- R10: Words 64 to 95 read a presence-detect table in the low byte of the read data, indexed by the word index minus 64. Entry 0 is 0x80, entry 1 is 0x08, entry 2 is 0x04, entry 3 is 0x0C, entry 4 is 0x0A, entry 5 is 0x01 and entry 6 is 0x40. Entry 31 is a density byte: 0x40 for 256 MB or more, 0x20 for 128, 0x10 for 64, 0x04 for 32, and 0x02 below that. All other entries are zero. Words 96 to 127 read zero. Writes to the window are ignored.
- R11: Words 32 to 35 and every other unassigned word index read zero. Writes to these indices leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the bank |
| bus_addr | input | 7 | Word index of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| led_o | output | 1 | LED drive, from control bit 0 |
| remap_o | output | 1 | High hides the boot flash at address zero |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the bus is quiet (`bus_we` low) while the internal reset synchroniser is still releasing. They also assume that `bus_addr` and `bus_wdata` are known whenever `bus_we` is high, because the reset-pulse and control-bit properties take their expected values from the write data. The stimulus changes inputs only on the falling clock edge. It holds `bus_we` low during and for several cycles after every reset, and it always drives fully defined addresses and data. The lock-key cases are ordered so that each protected write is tried once while locked and once while unlocked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 7;
  localparam int KEY_W  = 16;

  localparam logic [IDX_W-1:0] IX_IDENT  = 7'd0;
  localparam logic [IDX_W-1:0] IX_OSC    = 7'd2;
  localparam logic [IDX_W-1:0] IX_CTRL   = 7'd3;
  localparam logic [IDX_W-1:0] IX_STATUS = 7'd4;
  localparam logic [IDX_W-1:0] IX_KEY    = 7'd5;
  localparam logic [IDX_W-1:0] IX_AUXOSC = 7'd7;
  localparam logic [IDX_W-1:0] IX_MEMCFG = 7'd8;
  localparam logic [IDX_W-1:0] IX_MEMINI = 7'd9;
  localparam logic [IDX_W-1:0] IX_FSET   = 7'd12;
  localparam logic [IDX_W-1:0] IX_FCLR   = 7'd13;
  localparam logic [IDX_W-1:0] IX_NSET   = 7'd14;
  localparam logic [IDX_W-1:0] IX_NCLR   = 7'd15;

  localparam logic [WORD_W-1:0] IDENT_WORD  = 32'h411A_3001;
  localparam logic [WORD_W-1:0] STATUS_WORD = 32'h0010_0000;
  localparam logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F;

  localparam logic [WORD_W-1:0] OSC_RST    = 32'h0100_0048;
  localparam logic [WORD_W-1:0] AUXOSC_RST = 32'h0007_FEFF;
  localparam logic [WORD_W-1:0] MEMINI_RST = 32'h0000_0112;
  localparam logic [WORD_W-1:0] MEMCFG_BASE = 32'h0001_1122;

  // Control register bit positions (decoded by software, keep in place)
  localparam int CB_LED   = 0;
  localparam int CB_REMAP = 2;
  localparam int CB_RESET = 3;

  function automatic logic [7:0] mem_size_code(input int mb);
    if (mb >= 256)      return 8'h10;
    else if (mb >= 128) return 8'h0C;
    else if (mb >= 64)  return 8'h08;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h00;
  endfunction

  function automatic logic [7:0] mem_density_byte(input int mb);
    if (mb >= 256)      return 8'h40;
    else if (mb >= 128) return 8'h20;
    else if (mb >= 64)  return 8'h10;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h02;
  endfunction

  typedef struct packed {
    logic remap;
    logic led;
  } ctrl_t;
endpackage

// File: rtl/sysctl_keylock.sv
module sysctl_keylock #(
  parameter int                KEY_W = 16,
  parameter logic [KEY_W-1:0]  KEY   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic [KEY_W-1:0] key_q,
  output logic             unlocked
);
  logic [KEY_W-1:0] key_d;

  always_comb begin
    key_d = key_q;
    if (wr_en) key_d = wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign unlocked = (key_q == KEY);
endmodule

// File: rtl/sysctl_wreg.sv
module sysctl_wreg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= d;
  end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (set_en)      d = q | mask;
    else if (clr_en) d = q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/sysctl_spd_rom.sv
module sysctl_spd_rom #(
  parameter int MEM_MB = 128,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);
  import sysctl_pkg::*;
  localparam int          LAST    = (1 << IDX_W) - 1;
  localparam logic [7:0]  DENSITY = mem_density_byte(MEM_MB);

  always_comb begin
    unique case (int'(idx))
      0:       data = 8'h80;
      1:       data = 8'h08;
      2:       data = 8'h04;
      3:       data = 8'h0C;
      4:       data = 8'h0A;
      5:       data = 8'h01;
      6:       data = 8'h40;
      LAST:    data = DENSITY;
      default: data = 8'h00;
    endcase
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank #(
  parameter int MEM_MB = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        led_o,
  output logic        remap_o,
  output logic        sys_reset_req_o
);
  import sysctl_pkg::*;

  localparam int          SPD_IDX_W  = IDX_W - 2;
  localparam logic [31:0] MEMCFG_RST = MEMCFG_BASE | {24'h0, mem_size_code(MEM_MB)};
  localparam int          NFLAG      = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // write decode
  logic hit_osc, hit_aux, hit_ctrl, hit_key, hit_mcfg, hit_mini;
  logic [NFLAG-1:0] hit_set, hit_clr;

  always_comb begin
    hit_osc    = bus_we && (bus_addr == IX_OSC);
    hit_aux    = bus_we && (bus_addr == IX_AUXOSC);
    hit_ctrl   = bus_we && (bus_addr == IX_CTRL);
    hit_key    = bus_we && (bus_addr == IX_KEY);
    hit_mcfg   = bus_we && (bus_addr == IX_MEMCFG);
    hit_mini   = bus_we && (bus_addr == IX_MEMINI);
    hit_set[0] = bus_we && (bus_addr == IX_FSET);
    hit_clr[0] = bus_we && (bus_addr == IX_FCLR);
    hit_set[1] = bus_we && (bus_addr == IX_NSET);
    hit_clr[1] = bus_we && (bus_addr == IX_NCLR);
  end

  // key lock
  logic [KEY_W-1:0] key_q;
  logic             unlocked;

  sysctl_keylock #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (hit_key),
    .wr_key   (bus_wdata[KEY_W-1:0]),
    .key_q    (key_q),
    .unlocked (unlocked)
  );

  // plain word registers
  logic [31:0] osc_q, aux_q, mcfg_q, mini_q;

  sysctl_wreg #(.W(WORD_W), .RST(OSC_RST)) u_osc (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(hit_osc && unlocked),
    .wr_data(bus_wdata), .q(osc_q));

  sysctl_wreg #(.W(WORD_W), .RST(AUXOSC_RST)) u_aux (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(hit_aux && unlocked),
    .wr_data(bus_wdata), .q(aux_q));

  sysctl_wreg #(.W(WORD_W), .RST(MEMCFG_RST)) u_mcfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(hit_mcfg),
    .wr_data(bus_wdata), .q(mcfg_q));

  sysctl_wreg #(.W(WORD_W), .RST(MEMINI_RST)) u_mini (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(hit_mini),
    .wr_data(bus_wdata), .q(mini_q));

  // flag registers: main and non-volatile
  logic [NFLAG-1:0][31:0] flag_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sysctl_setclr #(.W(WORD_W)) u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_en (hit_set[g]),
      .clr_en (hit_clr[g]),
      .mask   (bus_wdata),
      .q      (flag_q[g])
    );
  end

  // control register and reset pulse
  ctrl_t ctrl_q, ctrl_d;
  logic  rreq_q, rreq_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit_ctrl) begin
      ctrl_d.led   = bus_wdata[CB_LED];
      ctrl_d.remap = bus_wdata[CB_REMAP];
    end
    rreq_d = hit_ctrl && bus_wdata[CB_RESET];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      rreq_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rreq_q <= rreq_d;
    end
  end

  assign led_o           = ctrl_q.led;
  assign remap_o         = ctrl_q.remap;
  assign sys_reset_req_o = rreq_q;

  // presence-detect window
  logic [7:0] spd_byte;

  sysctl_spd_rom #(.MEM_MB(MEM_MB), .IDX_W(SPD_IDX_W)) u_spd (
    .idx  (bus_addr[SPD_IDX_W-1:0]),
    .data (spd_byte)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[IDX_W-1]) begin
      if (!bus_addr[IDX_W-2]) bus_rdata = {24'h0, spd_byte};
    end else begin
      unique case (bus_addr)
        IX_IDENT:  bus_rdata = IDENT_WORD;
        IX_OSC:    bus_rdata = osc_q;
        IX_CTRL: begin
          bus_rdata[CB_LED]   = ctrl_q.led;
          bus_rdata[CB_REMAP] = ctrl_q.remap;
        end
        IX_STATUS: bus_rdata = STATUS_WORD;
        IX_KEY:    bus_rdata = {15'h0, unlocked, key_q};
        IX_AUXOSC: bus_rdata = aux_q;
        IX_MEMCFG: bus_rdata = mcfg_q;
        IX_MEMINI: bus_rdata = mini_q;
        IX_FSET:   bus_rdata = flag_q[0];
        IX_NSET:   bus_rdata = flag_q[1];
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        led_o,
  input logic        remap_o,
  input logic        sys_reset_req_o
);
  import sysctl_pkg::*;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic ctrl_wr, rst_wr;
  assign ctrl_wr = bus_we && (bus_addr == IX_CTRL);
  assign rst_wr  = ctrl_wr && bus_wdata[CB_RESET];

  // R6
  a_r6_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> sys_reset_req_o);

  // R6
  a_r6_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sys_reset_req_o) |-> $past(rst_wr));

  // R5
  a_r5_ctrl_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (led_o == $past(bus_wdata[CB_LED])) && (remap_o == $past(bus_wdata[CB_REMAP])));

  // R5
  a_r5_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(led_o) && $stable(remap_o));

  // R5
  a_r5_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IX_CTRL) |-> (bus_rdata == {29'h0, remap_o, 1'b0, led_o}));

  // R2
  a_r2_ident_const: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IX_IDENT) |-> (bus_rdata == IDENT_WORD));

  // R3
  a_r3_key_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == IX_KEY) |-> (bus_rdata[31:17] == 15'h0));

  // R10
  a_r10_window_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[6:5] == 2'b11) |-> (bus_rdata == 32'h0));

  // R11
  a_r11_volt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[6:2] == 5'b01000) |-> (bus_rdata == 32'h0));
endmodule

bind sysctl_bank sysctl_bank_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .bus_addr        (bus_addr),
  .bus_we          (bus_we),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .led_o           (led_o),
  .remap_o         (remap_o),
  .sys_reset_req_o (sys_reset_req_o)
);

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        led_o, remap_o, sys_reset_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sysctl_bank #(.MEM_MB(128)) i_sysctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_o(led_o),
    .remap_o(remap_o), .sys_reset_req_o(sys_reset_req_o));

  typedef struct packed {
    logic        we;
    logic [6:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'd0,  32'h0,        32'h411A3001, 4'd2},  // R2
    '{1'b0, 7'd4,  32'h0,        32'h00100000, 4'd2},  // R2
    '{1'b0, 7'd2,  32'h0,        32'h01000048, 4'd1},  // R1
    '{1'b0, 7'd7,  32'h0,        32'h0007FEFF, 4'd1},  // R1
    '{1'b0, 7'd9,  32'h0,        32'h00000112, 4'd1},  // R1
    '{1'b0, 7'd8,  32'h0,        32'h0001112E, 4'd1},  // R1 size code for 128 MB
    '{1'b0, 7'd5,  32'h0,        32'h00000000, 4'd1},  // R1
    '{1'b1, 7'd2,  32'h12345678, 32'h0,        4'd4},  // R4 locked write
    '{1'b0, 7'd2,  32'h0,        32'h01000048, 4'd4},
    '{1'b1, 7'd5,  32'hFFFFA05F, 32'h0,        4'd3},  // R3 upper bits dropped
    '{1'b0, 7'd5,  32'h0,        32'h0001A05F, 4'd3},
    '{1'b1, 7'd2,  32'h12345678, 32'h0,        4'd4},  // R4 unlocked write
    '{1'b0, 7'd2,  32'h0,        32'h12345678, 4'd4},
    '{1'b1, 7'd7,  32'h0000ABCD, 32'h0,        4'd4},
    '{1'b0, 7'd7,  32'h0,        32'h0000ABCD, 4'd4},
    '{1'b1, 7'd5,  32'h00001234, 32'h0,        4'd3},  // R3 relock
    '{1'b0, 7'd5,  32'h0,        32'h00001234, 4'd3},
    '{1'b1, 7'd7,  32'h00000000, 32'h0,        4'd4},  // R4 ignored again
    '{1'b0, 7'd7,  32'h0,        32'h0000ABCD, 4'd4},
    '{1'b1, 7'd3,  32'hFFFFFFF7, 32'h0,        4'd5},  // R5 only bits 0 and 2 kept
    '{1'b0, 7'd3,  32'h0,        32'h00000005, 4'd5},
    '{1'b1, 7'd12, 32'h000000F0, 32'h0,        4'd7},  // R7
    '{1'b1, 7'd12, 32'h00000003, 32'h0,        4'd7},
    '{1'b0, 7'd12, 32'h0,        32'h000000F3, 4'd7},
    '{1'b1, 7'd13, 32'h000000A0, 32'h0,        4'd7},
    '{1'b0, 7'd12, 32'h0,        32'h00000053, 4'd7},
    '{1'b0, 7'd13, 32'h0,        32'h00000000, 4'd7},
    '{1'b1, 7'd14, 32'hFFFF0000, 32'h0,        4'd8},  // R8
    '{1'b1, 7'd15, 32'h0F000000, 32'h0,        4'd8},
    '{1'b0, 7'd14, 32'h0,        32'hF0FF0000, 4'd8},
    '{1'b0, 7'd12, 32'h0,        32'h00000053, 4'd8},
    '{1'b1, 7'd8,  32'hDEADBEEF, 32'h0,        4'd9},  // R9
    '{1'b0, 7'd8,  32'h0,        32'hDEADBEEF, 4'd9},
    '{1'b1, 7'd9,  32'h00000321, 32'h0,        4'd9},
    '{1'b0, 7'd9,  32'h0,        32'h00000321, 4'd9},
    '{1'b1, 7'd32, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    '{1'b0, 7'd32, 32'h0,        32'h00000000, 4'd11},
    '{1'b1, 7'd6,  32'hFFFFFFFF, 32'h0,        4'd11},
    '{1'b0, 7'd6,  32'h0,        32'h00000000, 4'd11},
    '{1'b0, 7'd12, 32'h0,        32'h00000053, 4'd11},
    '{1'b0, 7'd8,  32'h0,        32'hDEADBEEF, 4'd11},
    '{1'b0, 7'd64, 32'h0,        32'h00000080, 4'd10}, // R10
    '{1'b0, 7'd70, 32'h0,        32'h00000040, 4'd10},
    '{1'b0, 7'd80, 32'h0,        32'h00000000, 4'd10},
    '{1'b0, 7'd95, 32'h0,        32'h00000020, 4'd10}, // density for 128 MB
    '{1'b1, 7'd64, 32'hFFFFFFFF, 32'h0,        4'd10},
    '{1'b0, 7'd64, 32'h0,        32'h00000080, 4'd10},
    '{1'b0, 7'd127,32'h0,        32'h00000000, 4'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 output reset state
    chk("R1 led_o",   {31'h0, led_o},           32'h0);
    chk("R1 remap_o", {31'h0, remap_o},         32'h0);
    chk("R1 reset request", {31'h0, sys_reset_req_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].a, VEC[i].d);
      #1;
      if (!VEC[i].we)
        chk($sformatf("R%0d vector %0d", VEC[i].r, i), bus_rdata, VEC[i].e);
    end
    drive(1'b0, 7'd0, 32'h0);

    // R5 outputs after control write 0x5 earlier
    chk("R5 led_o high",   {31'h0, led_o},   32'h1);
    chk("R5 remap_o high", {31'h0, remap_o}, 32'h1);
    chk("R6 no pulse without bit 3", {31'h0, sys_reset_req_o}, 32'h0);

    // R5 clear LED, keep remap
    drive(1'b1, 7'd3, 32'h00000004);
    @(posedge clk); #1;
    chk("R5 led_o low",        {31'h0, led_o},   32'h0);
    chk("R5 remap_o kept",     {31'h0, remap_o}, 32'h1);

    // R6 reset pulse, one cycle, bit 3 reads zero
    drive(1'b1, 7'd3, 32'h0000000A);
    @(posedge clk); #1;
    chk("R6 pulse raised", {31'h0, sys_reset_req_o}, 32'h1);
    chk("R5 bit 1 dropped, remap cleared", {31'h0, remap_o}, 32'h0);
    drive(1'b0, 7'd3, 32'h0);
    #1;
    chk("R5 bit 3 reads zero", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R6 pulse single cycle", {31'h0, sys_reset_req_o}, 32'h0);

    // R6 back-to-back writes hold the request one cycle each
    drive(1'b1, 7'd3, 32'h00000008);
    drive(1'b1, 7'd3, 32'h00000009);
    #1;
    chk("R6 first of pair", {31'h0, sys_reset_req_o}, 32'h1);
    drive(1'b0, 7'd0, 32'h0);
    #1;
    chk("R6 second of pair", {31'h0, sys_reset_req_o}, 32'h1);
    chk("R5 led from second write", {31'h0, led_o}, 32'h1);
    @(posedge clk); #1;
    chk("R6 pair ends", {31'h0, sys_reset_req_o}, 32'h0);

    // R1 reset mid-run restores values
    do_reset();
    drive(1'b0, 7'd2, 32'h0); #1;
    chk("R1 oscillator after reset", bus_rdata, 32'h01000048);
    drive(1'b0, 7'd12, 32'h0); #1;
    chk("R1 flags after reset", bus_rdata, 32'h0);
    drive(1'b0, 7'd14, 32'h0); #1;
    chk("R1 nv flags after reset", bus_rdata, 32'h0);
    chk("R1 led_o after reset", {31'h0, led_o}, 32'h0);

    // R4 a key one bit off stays locked
    drive(1'b1, 7'd5, 32'h0000A05E);
    drive(1'b1, 7'd2, 32'hCAFEF00D);
    drive(1'b0, 7'd2, 32'h0); #1;
    chk("R4 near-miss key", bus_rdata, 32'h01000048);
    drive(1'b0, 7'd5, 32'h0); #1;
    chk("R3 near-miss key readback", bus_rdata, 32'h0000A05E);

    drive(1'b0, 7'd0, 32'h0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule